// File: doc/BRIEF.md
# BCD Watchdog Countdown Timer

This block is a watchdog timer programmed in binary-coded decimal. Software enters a period from 00.01 to 99.99 seconds through two byte-wide registers. One register holds the hundredths and the other holds the whole seconds. An internal four-digit BCD counter, which software cannot see, counts down by one hundredth on each pulse of a 100 Hz tick input. A tick that would bring the counter to zero raises a sticky watchdog flag and drives an active-low interrupt. The counter then reloads and the next period starts at once.

Software keeps the alarm away by touching either register at regular intervals. Any read or any write restarts the countdown from the entered value and clears the flag and the interrupt. A period of 00.00 turns the timer off. The register port is plain control: an access completes in the cycle it is presented, read data comes back in the same cycle, and the port has no back-pressure.

Top module: `wdt_bcd_watchdog`

## Requirements
- R1: Two bytes store the period. Select 0 is hundredths, with the tens of hundredths in bits 7:4 and the units in bits 3:0. Select 1 is whole seconds, with the tens in bits 7:4 and the units in bits 3:0. Each byte is written on its own, in either order.
- R2: Any read or write of either byte, presented with `reg_rd` or `reg_wr` high at a clock edge, does two things at that edge. It reloads the counter from the stored period, including a byte being written in that cycle. It also clears `wd_flag` to 0 and returns `wd_irq_n` to 1.
- R3: While the stored period is non-zero, each tick lowers the counter by 00.01 with BCD borrow across all four digits. The tick that would bring the counter to 00.00 sets `wd_flag` to 1 and `wd_irq_n` to 0 at that edge. After a reload of N hundredths, the Nth following tick is the one that expires.
- R4: After an expiry the counter reloads and a new period starts. `wd_flag` and `wd_irq_n` stay asserted until the next register access.
- R5: `reg_rdata` always returns the stored byte for the current select, in the same cycle, and never returns the running count.
- R6: A stored period of 00.00 disables the timer. Ticks are then ignored and `wd_flag` never sets.
- R7: If an access and an expiring tick fall in the same cycle, the access wins. The flag stays clear and the counter restarts from the full period.
- R8: After reset the stored period is 00.00, `wd_flag` is 0 and `wd_irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse at 100 Hz |
| reg_sel | input | 1 | Byte select: 0 hundredths, 1 seconds |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (restarts the countdown) |
| reg_wdata | input | 8 | Write data, two BCD digits |
| reg_rdata | output | 8 | Stored byte for reg_sel |
| wd_flag | output | 1 | Sticky expiry flag |
| wd_irq_n | output | 1 | Interrupt, active low |

## Verification
A register access and the tick that would expire the counter can reach the same clock edge. The bench loads a period of 00.02 and applies one tick. It then raises `reg_rd` and `tick` together for one cycle. It judges the result by the flag staying clear and by the expiry landing exactly two further ticks later, which shows that the counter was reloaded and not decremented. The bench also crosses a byte boundary on the borrow (01.00) and counts through the full 99.99 period.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] bcd_digit_t;

  // one BCD digit minus a borrow; wraps 0 -> 9
  function automatic bcd_digit_t bcd_digit_dec(input bcd_digit_t d, input logic bin,
                                               output logic bout);
    bout = bin && (d == 4'd0);
    if (!bin)           return d;
    else if (d == 4'd0) return 4'd9;
    else                return d - 4'd1;
  endfunction
endpackage

// File: rtl/wdt_reload_regs.sv
module wdt_reload_regs #(
  parameter int DATA_W    = 8,
  parameter int NUM_BYTES = 2,
  parameter int SEL_W     = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SEL_W-1:0]            sel,
  input  logic                        wr,
  input  logic                        rd,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  output logic [NUM_BYTES*DATA_W-1:0] period_cur,
  output logic [NUM_BYTES*DATA_W-1:0] period_next,
  output logic                        access
);
  logic [DATA_W-1:0] store_q [NUM_BYTES];

  assign access = wr | rd;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    logic hit;
    assign hit = wr && (sel == SEL_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   store_q[b] <= '0;
      else if (hit) store_q[b] <= wdata;
    end
    assign period_cur [b*DATA_W +: DATA_W] = store_q[b];
    assign period_next[b*DATA_W +: DATA_W] = hit ? wdata : store_q[b];
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NUM_BYTES; b++)
      if (sel == SEL_W'(b)) rdata = store_q[b];
  end
endmodule

// File: rtl/wdt_bcd_counter.sv
module wdt_bcd_counter
  import wdt_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [DIGITS*DIGIT_W-1:0] load_val,
  input  logic                      enable,
  input  logic                      tick,
  output logic [DIGITS*DIGIT_W-1:0] count,
  output logic                      expire
);
  localparam int CW = DIGITS * DIGIT_W;

  logic [CW-1:0] count_q, dec_val;
  logic [DIGITS:0] borrow;
  logic terminal;

  assign borrow[0] = 1'b1;
  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    always_comb begin
      logic bo;
      dec_val[i*DIGIT_W +: DIGIT_W] =
        bcd_digit_dec(count_q[i*DIGIT_W +: DIGIT_W], borrow[i], bo);
      borrow[i+1] = bo;
    end
  end

  // at 00.01 (or an unexpected 00.00) the next tick ends the period
  assign terminal = (count_q[CW-1:1] == '0);
  assign expire   = !load && enable && tick && terminal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   count_q <= '0;
    else if (load)                count_q <= load_val;
    else if (expire)              count_q <= load_val;
    else if (enable && tick)      count_q <= dec_val;
  end

  assign count = count_q;
endmodule

// File: rtl/wdt_alarm.sv
module wdt_alarm (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic expire,
  output logic flag,
  output logic irq_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      irq_n <= 1'b1;
    end else if (clear) begin
      flag  <= 1'b0;
      irq_n <= 1'b1;
    end else if (expire) begin
      flag  <= 1'b1;
      irq_n <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_bcd_watchdog.sv
module wdt_bcd_watchdog #(
  parameter int DIGITS = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              wd_flag,
  output logic              wd_irq_n
);
  localparam int CNT_W     = DIGITS * wdt_pkg::DIGIT_W;
  localparam int NUM_BYTES = CNT_W / DATA_W;

  logic [CNT_W-1:0] period_cur, period_next, count;
  logic access, expire, enabled;

  wdt_reload_regs #(.DATA_W(DATA_W), .NUM_BYTES(NUM_BYTES), .SEL_W(1)) u_regs (
    .clk, .rst_n, .sel(reg_sel), .wr(reg_wr), .rd(reg_rd), .wdata(reg_wdata),
    .rdata(reg_rdata), .period_cur, .period_next, .access
  );

  assign enabled = (period_cur != '0);

  wdt_bcd_counter #(.DIGITS(DIGITS)) u_cnt (
    .clk, .rst_n, .load(access), .load_val(period_next), .enable(enabled),
    .tick, .count, .expire
  );

  wdt_alarm u_alarm (
    .clk, .rst_n, .clear(access), .expire, .flag(wd_flag), .irq_n(wd_irq_n)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         reg_wr,
  input logic         reg_rd,
  input logic         wd_flag,
  input logic         wd_irq_n,
  input logic [W-1:0] period_val,
  input logic [W-1:0] count_val
);
  AST_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |=> (!wd_flag && wd_irq_n)); // R2
  AST_SET_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wd_flag) |=> !wd_flag); // R3
  AST_IRQ_SET_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && wd_irq_n) |=> wd_irq_n); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_flag && !reg_wr && !reg_rd) |=> wd_flag); // R4
  AST_RUNNING_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (period_val != '0) |-> (count_val != '0)); // R3
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (period_val == '0 && !wd_flag) |=> !wd_flag); // R6
  AST_COLLISION_ACCESS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && reg_rd) |=> !wd_flag); // R7
endmodule

bind wdt_bcd_watchdog wdt_checker #(.W(CNT_W)) u_chk (
  .clk, .rst_n, .tick, .reg_wr, .reg_rd, .wd_flag, .wd_irq_n,
  .period_val(period_cur), .count_val(count)
);

// File: tb/tb_wdt_bcd_watchdog.sv
module tb_wdt_bcd_watchdog;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic wd_flag, wd_irq_n;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  wdt_bcd_watchdog dut (.*);

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk) begin reg_sel = s; reg_wdata = d; reg_wr = 1'b1; end
    @(negedge clk) reg_wr = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [7:0] d);
    @(negedge clk) begin reg_sel = s; reg_rd = 1'b1; end
    #1 d = reg_rdata;
    @(negedge clk) reg_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R8 flag", wd_flag, 0);
    check("R8 irq_n", wd_irq_n, 1);
    rd(1'b0, v); check("R8 hundredths", v, 8'h00);
    rd(1'b1, v); check("R8 seconds", v, 8'h00);
  endtask

  task automatic t_basic;
    logic [7:0] v;
    wr(1'b1, 8'h00); wr(1'b0, 8'h03);
    ticks(2); check("R3 before expiry", wd_flag, 0);
    ticks(1); check("R3 flag", wd_flag, 1); check("R3 irq_n", wd_irq_n, 0);
    ticks(5); check("R4 sticky flag", wd_flag, 1); check("R4 sticky irq", wd_irq_n, 0);
    rd(1'b0, v); check("R5 readback", v, 8'h03);
    check("R2 read clears flag", wd_flag, 0); check("R2 read clears irq", wd_irq_n, 1);
  endtask

  task automatic t_restart_borrow;
    logic [7:0] v;
    wr(1'b0, 8'h12);                        // period 00.12, digit borrow at 10 -> 09
    ticks(11);
    rd(1'b0, v); check("R5 not running count", v, 8'h12);
    ticks(11); check("R2 read restarted", wd_flag, 0);
    ticks(1);  check("R3 BCD borrow expiry", wd_flag, 1);
  endtask

  task automatic t_byte_borrow;
    wr(1'b0, 8'h00); wr(1'b1, 8'h01);      // 01.00, seconds written second
    ticks(99); check("R1 R3 cross-byte before", wd_flag, 0);
    ticks(1);  check("R1 R3 cross-byte expiry", wd_flag, 1);
    wr(1'b1, 8'h00); check("R2 write clears flag", wd_flag, 0);
  endtask

  task automatic t_disable;
    wr(1'b0, 8'h00); wr(1'b1, 8'h00);
    ticks(300);
    check("R6 disabled flag", wd_flag, 0); check("R6 disabled irq", wd_irq_n, 1);
  endtask

  task automatic t_collision;
    wr(1'b0, 8'h02);
    ticks(1);
    @(negedge clk) begin tick = 1'b1; reg_rd = 1'b1; reg_sel = 1'b0; end
    @(negedge clk) begin tick = 1'b0; reg_rd = 1'b0; end
    check("R7 access wins", wd_flag, 0);
    ticks(1); check("R7 full reload", wd_flag, 0);
    ticks(1); check("R7 expiry after reload", wd_flag, 1);
  endtask

  task automatic t_max;
    wr(1'b0, 8'h99); wr(1'b1, 8'h99);
    ticks(9998); check("R3 max before", wd_flag, 0);
    ticks(1);    check("R3 max expiry", wd_flag, 1); check("R3 max irq", wd_irq_n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_restart_borrow();
    t_byte_borrow();
    t_disable();
    t_collision();
    t_max();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule